// File: doc/BRIEF.md
# Processor reset exception sequencer

This block brings a processor core out of reset. While the active-low reset input is low, all activity stops and cannot be resumed. The status register image is forced to supervisor mode with tracing off, the master bit clear and the interrupt mask at its highest level. The vector base is cleared and every local-memory enable is cleared. None of these values changes afterwards, since software access to them is not part of this block.

Once reset is released, the block waits a fixed number of clock cycles. Throughout that window it keeps a sticky record of a debug halt request. If no halt was requested, it reads two longwords through a simple request/acknowledge bus master port: the word at address 0 becomes the stack pointer and the word at address 4 becomes the program counter. It then pulses a fetch-start strobe so that instruction fetch can begin.

The block enters a halted state that only reset clears when any of these occurs:
- a bus error arrives during either vector read;
- a bus error arrives before the first instruction reports completion;
- a fault is reported while exception processing is active.

Top module: `rst_boot_seq`

## Requirements
- R1: `sr` reads 16'h2700 (bit 15 trace = 0, bit 13 supervisor = 1, bit 12 master = 0, bits 10:8 interrupt mask = 7), `vbr` reads 0 and `mem_en` reads all zeros, both in reset and in every later cycle.
- R2: While `rst_n` is low, `bus_req`, `halted` and `fetch_start` are 0 and `sp` and `pc` are 0. Pulling `rst_n` low during a vector read drops `bus_req` at once.
- R3: After `rst_n` goes high, `bus_req` is first seen high after exactly WAIT_CYCLES (default 80) rising clock edges.
- R4: If `dbg_halt_req` is high at any of the WAIT_CYCLES edges of the wait window, `halted` rises after the last of those edges and `bus_req` never rises. A request after the window has no effect.
- R5: The first read drives `bus_addr` = 0. `bus_req` and `bus_addr` stay unchanged until `bus_ack` or `bus_err`, and an acknowledge loads `bus_rdata` into `sp`.
- R6: The second read drives `bus_addr` = 4. Its acknowledge loads `bus_rdata` into `pc`. `fetch_start` is then high for exactly the one cycle after that edge, and `bus_req` is low from then on.
- R7: `bus_err` during either vector read raises `halted` on the next cycle. `bus_req` drops, `fetch_start` never pulses, and a register whose read failed keeps its value. If `bus_ack` and `bus_err` are both high, the error wins.
- R8: From the release of reset until `first_instr_done`, a `nested_fault` raises `halted`. A `bus_err` after the program counter has been loaded also raises `halted`.
- R9: After `first_instr_done`, `bus_err` has no effect on `halted`, but `nested_fault` still raises it.
- R10: Once `halted` is high it stays high until `rst_n` is pulled low. A later release starts the whole sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| dbg_halt_req | input | 1 | Debug halt request, sampled during the wait window |
| nested_fault | input | 1 | Fault reported while exception processing is active |
| first_instr_done | input | 1 | First instruction has completed |
| bus_req | output | 1 | Read request |
| bus_addr | output | AW | Read address (0 or 4) |
| bus_rdata | input | DW | Read data |
| bus_ack | input | 1 | Read completed |
| bus_err | input | 1 | Access or address error response |
| sp | output | DW | Stack pointer |
| pc | output | DW | Program counter |
| sr | output | 16 | Status register image |
| vbr | output | AW | Vector base |
| mem_en | output | MEM_N | Local-memory enables |
| halted | output | 1 | Halted state |
| fetch_start | output | 1 | One-cycle strobe: instruction fetch may start |

## Verification
The bench probes the wait-window boundary from both sides:
- A halt request on the first or the last edge of the window must halt the core. A counter off by one would fetch vectors anyway.
- A request one edge late must be ignored. A design that sampled too long would halt a core that should boot.

It injects errors on the stack-pointer read, on the program-counter read, and with an acknowledge in the same cycle. A wrong priority there would load a faulted value or pulse fetch start.

It drives bus errors and nested faults on both sides of `first_instr_done` to confirm where the fault-on-fault window ends. It also pulls reset in the middle of a read with a slow responder. A design that kept the request pending would corrupt the following boot.

// File: rtl/rst_boot_seq.sv
module rst_boot_seq #(
  parameter int WAIT_CYCLES = 80,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int MEM_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbg_halt_req,
  input  logic             nested_fault,
  input  logic             first_instr_done,
  output logic             bus_req,
  output logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_rdata,
  input  logic             bus_ack,
  input  logic             bus_err,
  output logic [DW-1:0]    sp,
  output logic [DW-1:0]    pc,
  output logic [15:0]      sr,
  output logic [AW-1:0]    vbr,
  output logic [MEM_N-1:0] mem_en,
  output logic             halted,
  output logic             fetch_start
);

  localparam int CW = $clog2(WAIT_CYCLES + 1);
  localparam logic [15:0] SR_RESET = 16'h2700;
  localparam logic [CW-1:0] CNT_LOAD = CW'(WAIT_CYCLES - 1);

  typedef enum logic [2:0] {
    ST_WAIT, ST_SP, ST_PC, ST_RUN, ST_DONE, ST_HALT
  } st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic          seen;
  logic          fs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_WAIT;
      cnt   <= CNT_LOAD;
      seen  <= 1'b0;
      sp    <= '0;
      pc    <= '0;
      fs_q  <= 1'b0;
    end else begin
      fs_q <= 1'b0;
      case (state)
        ST_WAIT:
          if (nested_fault) state <= ST_HALT;
          else if (cnt == '0) state <= (seen || dbg_halt_req) ? ST_HALT : ST_SP;
          else begin
            cnt  <= cnt - 1'b1;
            seen <= seen | dbg_halt_req;
          end
        ST_SP:
          if (nested_fault || bus_err) state <= ST_HALT;
          else if (bus_ack) begin
            sp    <= bus_rdata;
            state <= ST_PC;
          end
        ST_PC:
          if (nested_fault || bus_err) state <= ST_HALT;
          else if (bus_ack) begin
            pc    <= bus_rdata;
            fs_q  <= 1'b1;
            state <= ST_RUN;
          end
        ST_RUN:
          if (nested_fault || bus_err) state <= ST_HALT;
          else if (first_instr_done) state <= ST_DONE;
        ST_DONE:
          if (nested_fault) state <= ST_HALT;
        default: state <= ST_HALT;
      endcase
    end
  end

  assign bus_req     = (state == ST_SP) || (state == ST_PC);
  assign bus_addr    = (state == ST_PC) ? AW'(4) : '0;
  assign halted      = (state == ST_HALT);
  assign fetch_start = fs_q;
  assign sr          = SR_RESET;
  assign vbr         = '0;
  assign mem_en      = '0;

  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack && !bus_err && !nested_fault) |=> (bus_req && $stable(bus_addr)));

  a_r6_fetch_once: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |=> !fetch_start);

  a_r6_fetch_after_pc: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |-> $past(bus_req && bus_ack && !bus_err && bus_addr == AW'(4)));

  a_r7_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_err) |=> (halted && !fetch_start));

  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  a_r4_no_req_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !bus_req);

  a_r3_req_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> (bus_addr == '0));

endmodule

// File: tb/rst_boot_seq_test.sv
`timescale 1ns/1ps
module rst_boot_seq_test;
  localparam int WAITC = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_halt_req = 1'b0, nested_fault = 1'b0, first_instr_done = 1'b0;
  logic bus_ack = 1'b0, bus_err = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic bus_req, halted, fetch_start;
  logic [31:0] bus_addr, sp, pc, vbr;
  logic [15:0] sr;
  logic [1:0] mem_en;

  rst_boot_seq uut (
    .clk(clk), .rst_n(rst_n), .dbg_halt_req(dbg_halt_req), .nested_fault(nested_fault),
    .first_instr_done(first_instr_done), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err), .sp(sp), .pc(pc),
    .sr(sr), .vbr(vbr), .mem_en(mem_en), .halted(halted), .fetch_start(fetch_start)
  );

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  int m_st, m_edges, m_seen, m_fs;
  logic [31:0] m_sp, m_pc;
  int lat = 1, rcnt = 0, err_addr = -1;
  logic [31:0] v_sp = 32'h1000_0FF0, v_pc = 32'h0000_0400;
  bit both_resp = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_edges = 0; m_seen = 0; m_fs = 0; m_sp = '0; m_pc = '0;
  endtask

  task automatic model_edge();
    m_fs = 0;
    case (m_st)
      0: begin
        m_edges++;
        if (nested_fault) m_st = 5;
        else begin
          if (dbg_halt_req) m_seen = 1;
          if (m_edges == WAITC) m_st = m_seen ? 5 : 1;
        end
      end
      1, 2: begin
        if (nested_fault || bus_err) m_st = 5;
        else if (bus_ack) begin
          if (m_st == 1) begin m_sp = bus_rdata; m_st = 2; end
          else begin m_pc = bus_rdata; m_fs = 1; m_st = 3; end
        end
      end
      3: if (nested_fault || bus_err) m_st = 5; else if (first_instr_done) m_st = 4;
      4: if (nested_fault) m_st = 5;
      default: ;
    endcase
  endtask

  task automatic compare();
    check("R5/R6 bus_req", 32'(bus_req), 32'((m_st == 1 || m_st == 2) ? 1 : 0));
    check("R5/R6 bus_addr", bus_addr, (m_st == 2) ? 32'd4 : 32'd0);
    check("R10 halted", 32'(halted), 32'(m_st == 5 ? 1 : 0));
    check("R6 fetch_start", 32'(fetch_start), 32'(m_fs));
    check("R5 sp", sp, m_sp);
    check("R6 pc", pc, m_pc);
    check("R1 sr", 32'(sr), 32'h2700);
    check("R1 vbr", vbr, 32'd0);
    check("R1 mem_en", 32'(mem_en), 32'd0);
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) model_edge();
    @(negedge clk);
    compare();
    if (bus_ack || bus_err) begin
      bus_ack = 1'b0; bus_err = 1'b0; rcnt = 0;
    end else if (bus_req) begin
      rcnt++;
      if (rcnt >= lat) begin
        bus_rdata = (bus_addr == 32'd0) ? v_sp : v_pc;
        if (int'(bus_addr) == err_addr) begin
          bus_err = 1'b1;
          bus_ack = both_resp;
        end else bus_ack = 1'b1;
      end
    end else rcnt = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    dbg_halt_req = 0; nested_fault = 0; first_instr_done = 0;
    bus_ack = 0; bus_err = 0; rcnt = 0;
    model_reset();
    #1;
    check("R2 reset req", 32'(bus_req), 0);
    check("R2 reset halted", 32'(halted), 0);
    repeat (3) step();
    rst_n = 1'b1;
  endtask

  task automatic run_to_fetch(output bit got);
    got = 0;
    for (int i = 0; i < 300 && !got; i++) begin
      step();
      if (fetch_start) got = 1;
      if (halted) i = 300;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit got;
    int n;
    model_reset();

    // normal boot, wait length R3, vectors R5 R6, post-window R9
    do_reset();
    check("R1 sr after reset", 32'(sr), 32'h2700);
    n = 0;
    for (int i = 0; i < 200 && !bus_req; i++) begin step(); n++; end
    check("R3 wait length", n, WAITC);
    check("R5 first addr", bus_addr, 0);
    run_to_fetch(got);
    check("R6 fetch pulse seen", 32'(got), 1);
    check("R5 sp loaded", sp, v_sp);
    check("R6 pc loaded", pc, v_pc);
    step();
    check("R6 fetch one cycle", 32'(fetch_start), 0);
    check("R6 req low", 32'(bus_req), 0);
    first_instr_done = 1; step(); first_instr_done = 0;
    bus_err = 1; step(); step();
    check("R9 bus_err ignored", 32'(halted), 0);
    nested_fault = 1; step(); nested_fault = 0;
    check("R9 nested fault halts", 32'(halted), 1);
    repeat (5) step();
    check("R10 halt sticky", 32'(halted), 1);
    check("R1 sr after boot", 32'(sr), 32'h2700);

    // slow responder, bus_err before first instruction done R8
    lat = 4; v_sp = 32'hDEAD_0010; v_pc = 32'h0000_8000;
    do_reset();
    check("R10 reset clears halt", 32'(halted), 0);
    run_to_fetch(got);
    check("R6 slow fetch", 32'(got), 1);
    check("R6 slow pc", pc, v_pc);
    bus_err = 1; step(); step();
    check("R8 bus_err in run halts", 32'(halted), 1);

    // halt request at first edge R4
    lat = 1;
    do_reset();
    dbg_halt_req = 1; step(); dbg_halt_req = 0;
    got = 0;
    for (int i = 0; i < 100; i++) begin step(); if (bus_req) got = 1; end
    check("R4 halt at first edge no req", 32'(got), 0);
    check("R4 halt at first edge halted", 32'(halted), 1);

    // halt request at last edge R4
    do_reset();
    repeat (WAITC - 1) step();
    check("R4 not halted yet", 32'(halted), 0);
    dbg_halt_req = 1; step(); dbg_halt_req = 0;
    check("R4 halt at last edge", 32'(halted), 1);
    check("R4 last edge no req", 32'(bus_req), 0);

    // halt request one edge late R4
    do_reset();
    repeat (WAITC) step();
    dbg_halt_req = 1; step(); dbg_halt_req = 0;
    run_to_fetch(got);
    check("R4 late halt ignored", 32'(got), 1);
    check("R4 late halt not halted", 32'(halted), 0);

    // error on stack pointer read R7, with simultaneous ack
    err_addr = 0; both_resp = 1;
    do_reset();
    run_to_fetch(got);
    check("R7 sp err no fetch", 32'(got), 0);
    check("R7 sp err halted", 32'(halted), 1);
    check("R7 sp kept", sp, 0);
    both_resp = 0;

    // error on program counter read R7
    err_addr = 4;
    do_reset();
    run_to_fetch(got);
    check("R7 pc err no fetch", 32'(got), 0);
    check("R7 pc err halted", 32'(halted), 1);
    check("R7 sp loaded before err", sp, v_sp);
    check("R7 pc kept", pc, 0);
    err_addr = -1;

    // nested fault during wait R8
    do_reset();
    repeat (10) step();
    nested_fault = 1; step(); nested_fault = 0;
    check("R8 nested fault in wait", 32'(halted), 1);

    // reset in the middle of a read R2, restart R10
    lat = 30;
    do_reset();
    for (int i = 0; i < 200 && !bus_req; i++) step();
    repeat (5) step();
    check("R5 req held while pending", 32'(bus_req), 1);
    @(negedge clk); rst_n = 1'b0; model_reset(); #1;
    check("R2 reset aborts read", 32'(bus_req), 0);
    check("R2 sp zero in reset", sp, 0);
    lat = 2;
    do_reset();
    run_to_fetch(got);
    check("R10 reboot after abort", 32'(got), 1);
    check("R10 reboot pc", pc, v_pc);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule